// File: doc/BRIEF.md
# Segmented DAC Switch Decoder

This block turns an 8-bit sample code into the switch-control word for a current-steering converter. The current sources are split into two groups. The five upper code bits pick how many of 31 equal major segments conduct, each worth 8 LSB. The three lower code bits drive three binary-weighted sources worth 1, 2 and 4 LSB. Every source has two steering controls, one for the true output and one for the complementary output. An awake source always conducts into exactly one of the two outputs.

The code is sampled on every rising clock edge and decoded. The decoded word is then registered a second time, so every switch changes on the same edge. A code sampled at one edge drives the switches after the following edge. An active-high sleep input turns every source off on both sides. Two 8-bit count outputs report, in LSB units, the current that the registered enables send to each output. A bench uses them to compare the switch word with the code.

The converter takes one sample on every clock, so the data path has no handshake. A new code is accepted on each edge, and the block never applies back-pressure.

Top module: `seg_dac_switch_dec`

## Requirements
- R1: A code on `code_in` at rising edge k is reflected on every switch and count output right after rising edge k+1, which gives two cycles of latency.
- R2: Major segment `seg_p[i]` is on exactly when i is less than the upper five code bits `code[7:3]`. Segments fill from index 0 upward as the value rises.
- R3: Binary source `bin_p[j]` equals code bit j, for j = 0..2, with a weight of 2^j LSB.
- R4: When the code steps up by one from a value whose low three bits are 111, all three binary sources go off and exactly one more major segment comes on.
- R5: While awake, `seg_n` is the bitwise inverse of `seg_p` and `bin_n` is the inverse of `bin_p`. No source is ever steered to both sides at once.
- R6: `cur_p` is 8 times the number of active true-side segments plus the weighted true-side binary sources, and it equals the code. `cur_n` equals 255 minus the code, so the two sum to 255 while awake.
- R7: When `sleep` is high at a rising edge, all four enable buses are zero after that edge, and both `cur_p` and `cur_n` read 0.
- R8: The input register keeps sampling while asleep. The first edge with `sleep` low shows the code sampled at the edge before it.
- R9: A synchronous active-high `rst` clears both register stages to code 0: `seg_p`=0, `bin_p`=0, `seg_n` all ones, `bin_n`=111, `cur_p`=0 and `cur_n`=255. Reset takes priority over `sleep`.
- R10: At code 128, sixteen segments are on, `cur_p`=128 and `cur_n`=127. At code 127, fifteen segments and all three binary sources are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Turns all sources off, active high |
| code_in | input | 8 | Sample code, unsigned |
| seg_p | output | 31 | Major segment enables, true side |
| seg_n | output | 31 | Major segment enables, complementary side |
| bin_p | output | 3 | Binary source enables, true side (bit j weighs 2^j) |
| bin_n | output | 3 | Binary source enables, complementary side |
| cur_p | output | 8 | True-side current in LSB units |
| cur_n | output | 8 | Complementary-side current in LSB units |

## Verification
An ascending sweep over all 256 codes crosses every carry from a low group of 111 into a new segment. A descending sweep crosses every borrow in the other direction. A scrambled stride sequence makes large jumps between neighbouring samples, so a wrong pipeline depth or a stale stage shows up as a mismatch. Alternating full-scale, zero and mid-scale codes test the extremes and the 127/128 boundary. Sleep windows with changing codes, and a reset asserted together with sleep, separate the off state, the resume value and the reset priority.

// File: rtl/seg_dac_pkg.sv
`timescale 1ns/1ps
package seg_dac_pkg;
  // Default split of the sample code: thermometer part and binary part.
  localparam int unsigned DEF_HI_W = 5;
  localparam int unsigned DEF_LO_W = 3;
endpackage

// File: rtl/seg_dac_capture.sv
`timescale 1ns/1ps
module seg_dac_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/seg_dac_thermo.sv
`timescale 1ns/1ps
module seg_dac_thermo #(
  parameter  int unsigned CNT_W = 5,
  localparam int unsigned N     = (1 << CNT_W) - 1
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [N-1:0]     therm
);
  // One comparator per segment: segment i conducts once the count passes i.
  for (genvar i = 0; i < N; i++) begin : g_seg
    assign therm[i] = (int'(cnt) > i);
  end
endmodule

// File: rtl/seg_dac_steer.sv
`timescale 1ns/1ps
module seg_dac_steer #(
  parameter int unsigned SEG_N = 31,
  parameter int unsigned LO_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic [SEG_N-1:0] therm,
  input  logic [LO_W-1:0]  bin,
  output logic [SEG_N-1:0] seg_p,
  output logic [SEG_N-1:0] seg_n,
  output logic [LO_W-1:0]  bin_p,
  output logic [LO_W-1:0]  bin_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_p <= '0;
      seg_n <= '1;
      bin_p <= '0;
      bin_n <= '1;
    end else if (sleep) begin
      seg_p <= '0;
      seg_n <= '0;
      bin_p <= '0;
      bin_n <= '0;
    end else begin
      seg_p <= therm;
      seg_n <= ~therm;
      bin_p <= bin;
      bin_n <= ~bin;
    end
  end

  AST_NO_DOUBLE_STEER: assert property (@(posedge clk) disable iff (rst)
    ((seg_p & seg_n) == '0) && ((bin_p & bin_n) == '0)); // R5

  AST_AWAKE_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> (&(seg_p | seg_n)) && (&(bin_p | bin_n))); // R5

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (seg_p == '0) && (seg_n == '0) && (bin_p == '0) && (bin_n == '0)); // R7
endmodule

// File: rtl/seg_dac_current.sv
`timescale 1ns/1ps
module seg_dac_current #(
  parameter int unsigned SEG_N  = 31,
  parameter int unsigned LO_W   = 3,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEG_N-1:0]  seg_p,
  input  logic [SEG_N-1:0]  seg_n,
  input  logic [LO_W-1:0]   bin_p,
  input  logic [LO_W-1:0]   bin_n,
  output logic [CODE_W-1:0] cur_p,
  output logic [CODE_W-1:0] cur_n
);
  localparam logic [CODE_W:0] FULL = (CODE_W+1)'((1 << CODE_W) - 1);

  function automatic logic [CODE_W-1:0] weigh(input logic [SEG_N-1:0] s,
                                              input logic [LO_W-1:0]  b);
    logic [CODE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(SEG_N); i++) acc = acc + (CODE_W'(s[i]) << LO_W);
    for (int j = 0; j < int'(LO_W); j++)  acc = acc + (CODE_W'(b[j]) << j);
    return acc;
  endfunction

  assign cur_p = weigh(seg_p, bin_p);
  assign cur_n = weigh(seg_n, bin_n);

  AST_SUM_FULL: assert property (@(posedge clk) disable iff (rst)
    ((&(seg_p | seg_n)) && (&(bin_p | bin_n))) |->
      ({1'b0, cur_p} + {1'b0, cur_n} == FULL)); // R6
endmodule

// File: rtl/seg_dac_switch_dec.sv
`timescale 1ns/1ps
module seg_dac_switch_dec #(
  parameter  int unsigned HI_W   = seg_dac_pkg::DEF_HI_W,
  parameter  int unsigned LO_W   = seg_dac_pkg::DEF_LO_W,
  localparam int unsigned CODE_W = HI_W + LO_W,
  localparam int unsigned SEG_N  = (1 << HI_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] code_in,
  output logic [SEG_N-1:0]  seg_p,
  output logic [SEG_N-1:0]  seg_n,
  output logic [LO_W-1:0]   bin_p,
  output logic [LO_W-1:0]   bin_n,
  output logic [CODE_W-1:0] cur_p,
  output logic [CODE_W-1:0] cur_n
);
  logic [CODE_W-1:0] code_q;
  logic [SEG_N-1:0]  therm;

  seg_dac_capture #(.W(CODE_W)) u_capture (
    .clk (clk),
    .rst (rst),
    .d   (code_in),
    .q   (code_q)
  );

  seg_dac_thermo #(.CNT_W(HI_W)) u_thermo (
    .cnt   (code_q[CODE_W-1:LO_W]),
    .therm (therm)
  );

  seg_dac_steer #(.SEG_N(SEG_N), .LO_W(LO_W)) u_steer (
    .clk   (clk),
    .rst   (rst),
    .sleep (sleep),
    .therm (therm),
    .bin   (code_q[LO_W-1:0]),
    .seg_p (seg_p),
    .seg_n (seg_n),
    .bin_p (bin_p),
    .bin_n (bin_n)
  );

  seg_dac_current #(.SEG_N(SEG_N), .LO_W(LO_W), .CODE_W(CODE_W)) u_current (
    .clk   (clk),
    .rst   (rst),
    .seg_p (seg_p),
    .seg_n (seg_n),
    .bin_p (bin_p),
    .bin_n (bin_n),
    .cur_p (cur_p),
    .cur_n (cur_n)
  );

  AST_SEG_COUNT: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> ($countones(seg_p) == int'($past(code_q[CODE_W-1:LO_W])))); // R2

  AST_CARRY_STEP: assert property (@(posedge clk) disable iff (rst)
    (($past(cur_p[LO_W-1:0]) == '1) &&
     ({1'b0, cur_p} == {1'b0, $past(cur_p)} + 1'b1)) |->
      ((bin_p == '0) && ($countones(seg_p) == $countones($past(seg_p)) + 1))); // R4
endmodule

// File: tb/seg_dac_switch_dec_tb.sv
`timescale 1ns/1ps
module seg_dac_switch_dec_tb;
  localparam int HI_W  = 5;
  localparam int LO_W  = 3;
  localparam int CW    = HI_W + LO_W;
  localparam int SEGN  = (1 << HI_W) - 1;
  localparam int FULLV = (1 << CW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sleep = 1'b0;
  logic [CW-1:0]   code_in = '0;
  logic [SEGN-1:0] seg_p, seg_n;
  logic [LO_W-1:0] bin_p, bin_n;
  logic [CW-1:0]   cur_p, cur_n;

  int checks = 0;
  int errors = 0;

  // Bench-side pipeline model
  int s1 = 0;
  int o_code = 0;
  bit o_sleep = 1'b0;

  always #4 clk = ~clk;

  seg_dac_switch_dec u_dut (
    .clk(clk), .rst(rst), .sleep(sleep), .code_in(code_in),
    .seg_p(seg_p), .seg_n(seg_n), .bin_p(bin_p), .bin_n(bin_n),
    .cur_p(cur_p), .cur_n(cur_n)
  );

  task automatic check_out(input string tag);
    logic [SEGN-1:0] e_sp, e_sn;
    logic [LO_W-1:0] e_bp, e_bn;
    int e_cp, e_cn;
    if (o_sleep) begin
      e_sp = '0; e_sn = '0; e_bp = '0; e_bn = '0; e_cp = 0; e_cn = 0;
    end else begin
      e_sp = SEGN'((64'd1 << (o_code >> LO_W)) - 64'd1);
      e_sn = ~e_sp;
      e_bp = LO_W'(o_code % (1 << LO_W));
      e_bn = ~e_bp;
      e_cp = o_code;
      e_cn = FULLV - o_code;
    end
    checks++;
    if (seg_p !== e_sp || seg_n !== e_sn || bin_p !== e_bp || bin_n !== e_bn ||
        int'(cur_p) != e_cp || int'(cur_n) != e_cn) begin
      errors++;
      $display("FAIL %s seg_p=%h/%h seg_n=%h/%h bin_p=%b/%b bin_n=%b/%b cur_p=%0d/%0d cur_n=%0d/%0d (actual/expected)",
               tag, seg_p, e_sp, seg_n, e_sn, bin_p, e_bp, bin_n, e_bn,
               cur_p, e_cp, cur_n, e_cn);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic tick(input int code, input bit slp, input string tag);
    code_in = CW'(code);
    sleep   = slp;
    @(posedge clk);
    if (rst) begin
      o_code = 0; o_sleep = 1'b0; s1 = 0;
    end else begin
      o_code = s1; o_sleep = slp; s1 = code;
    end
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic expect_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset state, also with sleep held high
    rst = 1'b1;
    tick(8'h5A, 1'b0, "R9");
    tick(8'hFF, 1'b1, "R9");
    tick(8'hC3, 1'b1, "R9");
    rst = 1'b0;

    // R1: two-cycle latency on a short distinct sequence
    tick(8'h3C, 1'b0, "R1");
    tick(8'hA7, 1'b0, "R1");
    expect_int("R1", int'(cur_p), 8'h3C);
    tick(8'h00, 1'b0, "R1");
    expect_int("R1", int'(cur_p), 8'hA7);

    // R2/R4: ascending sweep with explicit carry checks
    for (int c = 0; c < 256; c++) begin
      int prev_segs;
      int prev_cur;
      prev_segs = $countones(seg_p);
      prev_cur  = int'(cur_p);
      tick(c, 1'b0, "R2");
      if (prev_cur % 8 == 7 && int'(cur_p) == prev_cur + 1) begin
        expect_int("R4", int'(bin_p), 0);
        expect_int("R4", $countones(seg_p), prev_segs + 1);
      end
    end
    tick(0, 1'b0, "R2");

    // R3: descending sweep
    for (int c = 255; c >= 0; c--) tick(c, 1'b0, "R3");
    tick(0, 1'b0, "R3");

    // R6/R5: scrambled stride sequence, sum checked explicitly
    for (int k = 0; k < 256; k++) begin
      tick((k * 37 + 11) % 256, 1'b0, "R6");
      expect_int("R6", int'(cur_p) + int'(cur_n), FULLV);
      expect_int("R5", int'(seg_p & seg_n) + int'(bin_p & bin_n), 0);
    end

    // R10/R5: extremes and mid-scale
    for (int k = 0; k < 8; k++) begin
      tick(255, 1'b0, "R5");
      tick(0,   1'b0, "R5");
      tick(128, 1'b0, "R10");
      tick(127, 1'b0, "R10");
    end
    tick(200, 1'b0, "R10");
    expect_int("R10", $countones(seg_p), 15);
    expect_int("R10", int'(cur_n), 128);
    tick(200, 1'b0, "R10");
    expect_int("R10", $countones(seg_p), 25);

    // R7: sleep window with changing codes; R8: resume value
    tick(128, 1'b0, "R7");
    tick(90,  1'b0, "R7");
    for (int k = 0; k < 6; k++) begin
      tick(k * 40 + 3, 1'b1, "R7");
      expect_int("R7", int'(cur_p) + int'(cur_n), 0);
    end
    tick(17, 1'b0, "R8");
    expect_int("R8", int'(cur_p), 5 * 40 + 3);
    tick(66, 1'b0, "R8");
    expect_int("R8", int'(cur_p), 17);

    // R9: reset mid-run
    rst = 1'b1;
    tick(250, 1'b0, "R9");
    expect_int("R9", int'(cur_n), 255);
    rst = 1'b0;
    tick(9, 1'b0, "R9");
    tick(9, 1'b0, "R9");
    expect_int("R9", int'(cur_p), 9);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule